// File: doc/BRIEF.md
# Lockable Extended Graphics Register File

This block holds seven extended configuration registers behind an indexed I/O pair. A write to the index port picks a register; accesses to the data port then read or write the register that the index names. The extended registers sit at indices 0x09 to 0x0F. Two of them hold bank offsets, one describes the memory (installed size and a second-bank enable), and three hold video configuration, CRT control and video control. The last one, at 0x0F, is a key register that locks or unlocks the other six.

The block passes a few register fields straight to the rest of the display pipeline. These are:
- the two bank offsets;
- the second-bank enable;
- the top two bits (17:16) of the display start address and of the cursor start address;
- the pixel clock index, taken from the miscellaneous output register.

Writes are single-cycle strobes. Read data is combinational from the current index and the stored state.

Top module: `xgr_regfile`

## Requirements
- R1: A write with `io_sel`=0 stores the full byte as the current index. With `io_sel`=0, `io_rdata` returns that index. With `io_sel`=1, reads and writes go to the register that the current index names.
- R2: Indices 0x09 to 0x0E are locked whenever bits 2:0 of register 0x0F differ from 3'b101. A data-port read of a locked index returns 0x00, and `ext_locked` is 1 while locked.
- R3: A data-port write to a locked index 0x09 to 0x0E leaves that register unchanged, which a later read after unlocking shows.
- R4: Register 0x0F accepts and returns all 8 bits whatever the lock state.
- R5: A write to 0x0B changes only bit 3, and all other bits keep their value. `dual_bank_en` equals bit 3 of 0x0B.
- R6: Bits 7:6 of 0x0B take the value of `mem_size_cfg` during reset: 01 means 256 KB, 10 means 512 KB and 11 means 1 MB. Bits 5:0 reset to 0.
- R7: `disp_start_hi` and `cursor_start_hi` both equal bits 4:3 of 0x0D.
- R8: `clk_sel` equals bits 3:2 of `misc_out`.
- R9: A data-port write to an index outside 0x09 to 0x0F changes no register, and a data-port read of such an index returns 0x00.
- R10: After reset, the index is 0x00, registers 0x09, 0x0A, 0x0C, 0x0D and 0x0E are 0x00, and 0x0F is 0x05, so the block starts unlocked.
- R11: An accessible register reads back its whole stored byte, including bits that have no function.
- R12: `bank_a` and `bank_b` equal the stored values of 0x09 and 0x0A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_sel | input | 1 | 0 selects the index port, 1 selects the data port |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data for the selected port (combinational) |
| mem_size_cfg | input | 2 | Installed-memory code, loaded into 0x0B bits 7:6 during reset |
| misc_out | input | 8 | Value of the miscellaneous output register |
| bank_a | output | 8 | Bank offset from register 0x09 |
| bank_b | output | 8 | Bank offset from register 0x0A |
| dual_bank_en | output | 1 | Second-bank enable, bit 3 of 0x0B |
| disp_start_hi | output | 2 | Display start address bits 17:16 |
| cursor_start_hi | output | 2 | Cursor start address bits 17:16 |
| clk_sel | output | 2 | Active pixel clock index |
| ext_locked | output | 1 | 1 while indices 0x09 to 0x0E are locked |

## Verification
A wrong stored byte shows up on the very next data-port read of that index, provided the block is unlocked, and at once on the bank, dual-bank and start-address outputs. A wrong lock decision shows up in two ways. A locked read that returns non-zero data is visible in the same cycle. A locked write that slipped through is only visible after the key is restored and the register is read back, so the bench always reads back after unlocking. A wrong mask on 0x0B appears in the memory-size bits on the next read of that register.

// File: rtl/xgr_pkg.sv
// Package: shared constants for the extended graphics register file.
// Assumes an 8-bit data path and 8-bit index space.
package xgr_pkg;
    localparam int DATA_W     = 8;
    localparam int IDX_W      = 8;
    localparam int NREG       = 7;
    localparam int BASE_IDX   = 9;
    // register offsets from BASE_IDX (order is decoded by index)
    localparam int OFF_BANK_A = 0;
    localparam int OFF_BANK_B = 1;
    localparam int OFF_MEMCFG = 2;
    localparam int OFF_VIDCFG = 3;
    localparam int OFF_CRT    = 4;
    localparam int OFF_VIDCTL = 5;
    localparam int OFF_KEY    = 6;
    // field positions
    localparam int DUAL_BIT   = 3;
    localparam int MSZ_LSB    = 6;
    localparam int START_LSB  = 3;
    localparam int CLK_LSB    = 2;
    localparam int KEY_BITS   = 3;
    localparam int KEY_VALUE  = 5;
    localparam logic [DATA_W-1:0] KEY_RESET = 8'h05;
endpackage

// File: rtl/xgr_decode.sv
// Module: index decoder. Turns the current index into an in-range flag,
// a register offset, an access-allowed flag that honours the lock, and a
// one-hot write enable. Assumes BASE+NREG fits in the index space.
module xgr_decode #(
    parameter int IDX_W   = xgr_pkg::IDX_W,
    parameter int NREG    = xgr_pkg::NREG,
    parameter int BASE    = xgr_pkg::BASE_IDX,
    parameter int KEY_OFF = xgr_pkg::OFF_KEY
) (
    input  logic [IDX_W-1:0]          idx,
    input  logic                      data_wr,
    input  logic                      locked,
    output logic                      hit,
    output logic [$clog2(NREG)-1:0]   off,
    output logic                      allowed,
    output logic [NREG-1:0]           wr_en
);
    localparam int OFF_W = $clog2(NREG);
    localparam logic [IDX_W-1:0] BASE_V = IDX_W'(BASE);
    localparam logic [IDX_W-1:0] NREG_V = IDX_W'(NREG);
    localparam logic [OFF_W-1:0] KEY_V  = OFF_W'(KEY_OFF);

    logic [IDX_W-1:0] diff;

    // purpose: range test and offset extraction
    always_comb begin
        diff    = idx - BASE_V;
        hit     = (idx >= BASE_V) && (diff < NREG_V);
        off     = diff[OFF_W-1:0];
        allowed = hit && !(locked && (off != KEY_V));
    end

    // purpose: one write enable per register
    for (genvar g = 0; g < NREG; g++) begin : g_we
        assign wr_en[g] = data_wr && allowed && (off == OFF_W'(g));
    end
endmodule

// File: rtl/xgr_storage.sv
// Module: register storage. One byte per register; the memory-config
// register accepts only its bank-enable bit and loads its size field from
// a configuration input during reset; the key register resets to the
// unlock value. Assumes at most one write enable active per cycle.
module xgr_storage #(
    parameter int DATA_W  = xgr_pkg::DATA_W,
    parameter int NREG    = xgr_pkg::NREG,
    parameter int MEM_OFF = xgr_pkg::OFF_MEMCFG,
    parameter int KEY_OFF = xgr_pkg::OFF_KEY
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NREG-1:0]               wr_en,
    input  logic [DATA_W-1:0]             wdata,
    input  logic [1:0]                    mem_size_cfg,
    output logic [NREG-1:0][DATA_W-1:0]   regs
);
    import xgr_pkg::*;
    localparam logic [DATA_W-1:0] DUAL_MASK = DATA_W'(1) << DUAL_BIT;

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        if (g == MEM_OFF) begin : g_mem
            // purpose: size field from config at reset, only bit 3 writable
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    regs[g]                 <= '0;
                    regs[g][MSZ_LSB +: 2]   <= mem_size_cfg;
                end else if (wr_en[g]) begin
                    regs[g][DUAL_BIT]       <= wdata[DUAL_BIT];
                end
            end
            assert_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
                wr_en[g] |=> ((regs[g] & ~DUAL_MASK) == $past(regs[g] & ~DUAL_MASK))
                          && (regs[g][DUAL_BIT] == $past(wdata[DUAL_BIT])));
        end else if (g == KEY_OFF) begin : g_key
            // purpose: key register, reset to the unlock value
            always_ff @(posedge clk) begin
                if (!rst_n)        regs[g] <= KEY_RESET;
                else if (wr_en[g]) regs[g] <= wdata;
            end
        end else begin : g_plain
            // purpose: plain byte register
            always_ff @(posedge clk) begin
                if (!rst_n)        regs[g] <= '0;
                else if (wr_en[g]) regs[g] <= wdata;
            end
            assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
                !wr_en[g] |=> $stable(regs[g]));
        end
    end
endmodule

// File: rtl/xgr_readmux.sv
// Module: read path. Returns the index on the index port, the selected
// register byte on the data port when access is allowed, else zero.
module xgr_readmux #(
    parameter int DATA_W = xgr_pkg::DATA_W,
    parameter int IDX_W  = xgr_pkg::IDX_W,
    parameter int NREG   = xgr_pkg::NREG
) (
    input  logic                          sel_data,
    input  logic [IDX_W-1:0]              index_q,
    input  logic                          allowed,
    input  logic [$clog2(NREG)-1:0]       off,
    input  logic [NREG-1:0][DATA_W-1:0]   regs,
    output logic [DATA_W-1:0]             rdata
);
    localparam int OFF_W = $clog2(NREG);

    // purpose: port and register selection
    always_comb begin
        rdata = '0;
        if (!sel_data) begin
            rdata = DATA_W'(index_q);
        end else if (allowed) begin
            for (int g = 0; g < NREG; g++) begin
                if (off == OFF_W'(g)) rdata = regs[g];
            end
        end
    end
endmodule

// File: rtl/xgr_regfile.sv
// Module: top of the lockable extended graphics register file. Holds the
// index register, derives the lock from the key register and exports the
// register fields used by the display pipeline. Assumes single-cycle
// write strobes and a synchronous active-low reset.
module xgr_regfile (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       io_wr,
    input  logic       io_sel,
    input  logic [7:0] io_wdata,
    output logic [7:0] io_rdata,
    input  logic [1:0] mem_size_cfg,
    input  logic [7:0] misc_out,
    output logic [7:0] bank_a,
    output logic [7:0] bank_b,
    output logic       dual_bank_en,
    output logic [1:0] disp_start_hi,
    output logic [1:0] cursor_start_hi,
    output logic [1:0] clk_sel,
    output logic       ext_locked
);
    import xgr_pkg::*;
    localparam int OFF_W = $clog2(NREG);
    localparam logic [IDX_W-1:0] CRT_IDX = IDX_W'(BASE_IDX + OFF_CRT);
    localparam logic [IDX_W-1:0] KEY_IDX = IDX_W'(BASE_IDX + OFF_KEY);
    localparam logic [IDX_W-1:0] LO_IDX  = IDX_W'(BASE_IDX);

    logic [IDX_W-1:0]               index_q;
    logic [NREG-1:0][DATA_W-1:0]    regs;
    logic [NREG-1:0]                wr_en;
    logic                           hit;
    logic                           allowed;
    logic [OFF_W-1:0]               off;
    logic                           locked;
    logic                           data_wr;

    // purpose: index port register
    always_ff @(posedge clk) begin
        if (!rst_n)                index_q <= '0;
        else if (io_wr && !io_sel) index_q <= io_wdata;
    end

    // purpose: strobe qualification and lock decision
    always_comb begin
        data_wr = io_wr && io_sel;
        locked  = regs[OFF_KEY][KEY_BITS-1:0] != KEY_BITS'(KEY_VALUE);
    end

    xgr_decode #(.IDX_W(IDX_W), .NREG(NREG), .BASE(BASE_IDX), .KEY_OFF(OFF_KEY)) u_dec (
        .idx(index_q), .data_wr(data_wr), .locked(locked),
        .hit(hit), .off(off), .allowed(allowed), .wr_en(wr_en)
    );

    xgr_storage #(.DATA_W(DATA_W), .NREG(NREG), .MEM_OFF(OFF_MEMCFG), .KEY_OFF(OFF_KEY)) u_sto (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(io_wdata),
        .mem_size_cfg(mem_size_cfg), .regs(regs)
    );

    xgr_readmux #(.DATA_W(DATA_W), .IDX_W(IDX_W), .NREG(NREG)) u_rd (
        .sel_data(io_sel), .index_q(index_q), .allowed(allowed), .off(off),
        .regs(regs), .rdata(io_rdata)
    );

    // purpose: fields exported to the display pipeline
    always_comb begin
        bank_a          = regs[OFF_BANK_A];
        bank_b          = regs[OFF_BANK_B];
        dual_bank_en    = regs[OFF_MEMCFG][DUAL_BIT];
        disp_start_hi   = regs[OFF_CRT][START_LSB +: 2];
        cursor_start_hi = regs[OFF_CRT][START_LSB +: 2];
        clk_sel         = misc_out[CLK_LSB +: 2];
        ext_locked      = locked;
    end

    assert_locked_read_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (io_sel && ext_locked && index_q >= LO_IDX && index_q < KEY_IDX) |-> io_rdata == '0);

    assert_key_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_sel && index_q == KEY_IDX) |=> regs[OFF_KEY] == $past(io_wdata));

    assert_start_hi_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_sel && index_q == CRT_IDX && !ext_locked)
            |=> disp_start_hi == $past(io_wdata[4:3]));

    assert_out_of_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (io_sel && !hit) |-> io_rdata == '0);
endmodule

// File: tb/tb_xgr_regfile.sv
module tb_xgr_regfile;
    localparam int CLK_P = 10;

    logic       clk = 0;
    logic       rst_n = 0;
    logic       io_wr = 0;
    logic       io_sel = 0;
    logic [7:0] io_wdata = 0;
    logic [7:0] io_rdata;
    logic [1:0] mem_size_cfg = 2'b10;
    logic [7:0] misc_out = 0;
    logic [7:0] bank_a, bank_b;
    logic       dual_bank_en;
    logic [1:0] disp_start_hi, cursor_start_hi, clk_sel;
    logic       ext_locked;

    int checks = 0;
    int fails  = 0;
    logic [7:0] m [0:6];
    logic [7:0] idx_m;

    always #(CLK_P/2) clk = ~clk;

    xgr_regfile dut (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_sel(io_sel),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .mem_size_cfg(mem_size_cfg),
        .misc_out(misc_out), .bank_a(bank_a), .bank_b(bank_b),
        .dual_bank_en(dual_bank_en), .disp_start_hi(disp_start_hi),
        .cursor_start_hi(cursor_start_hi), .clk_sel(clk_sel), .ext_locked(ext_locked)
    );

    function automatic bit m_locked();
        return m[6][2:0] != 3'd5;
    endfunction

    function automatic bit in_rng(logic [7:0] i);
        return i >= 8'h09 && i <= 8'h0F;
    endfunction

    function automatic logic [7:0] exp_read(bit sel);
        if (!sel) return idx_m;
        if (!in_rng(idx_m)) return 8'h00;
        if (idx_m != 8'h0F && m_locked()) return 8'h00;
        return m[idx_m - 8'h09];
    endfunction

    function automatic string req_of();
        if (!in_rng(idx_m)) return "R9";
        if (idx_m != 8'h0F && m_locked()) return "R2";
        if (idx_m == 8'h0F) return "R4";
        if (idx_m == 8'h0B) return "R5";
        return "R11";
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic do_wr(bit sel, logic [7:0] d);
        @(negedge clk);
        io_wr = 1; io_sel = sel; io_wdata = d;
        @(negedge clk);
        io_wr = 0;
        if (!sel) idx_m = d;
        else if (in_rng(idx_m) && (idx_m == 8'h0F || !m_locked())) begin
            if (idx_m == 8'h0B) m[2][3] = d[3];
            else m[idx_m - 8'h09] = d;
        end
    endtask

    task automatic rd_chk(bit sel, string req);
        io_sel = sel;
        #1;
        chk(req, io_rdata, exp_read(sel));
    endtask

    task automatic out_chk();
        #1;
        chk("R12", bank_a, m[0]);
        chk("R12", bank_b, m[1]);
        chk("R5",  {7'd0, dual_bank_en}, {7'd0, m[2][3]});
        chk("R7",  {6'd0, disp_start_hi}, {6'd0, m[4][4:3]});
        chk("R7",  {6'd0, cursor_start_hi}, {6'd0, m[4][4:3]});
        chk("R8",  {6'd0, clk_sel}, {6'd0, misc_out[3:2]});
        chk("R2",  {7'd0, ext_locked}, {7'd0, m_locked()});
    endtask

    task automatic do_reset(logic [1:0] cfg);
        mem_size_cfg = cfg;
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        for (int i = 0; i < 7; i++) m[i] = 8'h00;
        m[2] = {cfg, 6'd0};
        m[6] = 8'h05;
        idx_m = 8'h00;
    endtask

    initial begin
        #(CLK_P * 200000);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        // R10/R6 reset state for each memory size code
        for (int c = 1; c < 4; c++) begin
            do_reset(2'(c));
            rd_chk(0, "R10");
            for (int i = 9; i <= 15; i++) begin
                do_wr(0, 8'(i));
                rd_chk(1, (i == 11) ? "R6" : "R10");
            end
        end
        // R1 index port round trip
        do_wr(0, 8'hA5); rd_chk(0, "R1");
        // R5 mask: write all ones to 0x0B
        do_wr(0, 8'h0B); do_wr(1, 8'hFF); rd_chk(1, "R5");
        do_wr(1, 8'h00); rd_chk(1, "R5");
        // R3 locked write ignored, then seen after unlock
        do_wr(0, 8'h09); do_wr(1, 8'h3C);
        do_wr(0, 8'h0F); do_wr(1, 8'hF8); rd_chk(1, "R4");
        do_wr(0, 8'h09); rd_chk(1, "R2");
        do_wr(1, 8'hC3);
        do_wr(0, 8'h0F); do_wr(1, 8'h0D);
        do_wr(0, 8'h09); rd_chk(1, "R3"); chk("R3", bank_a, 8'h3C);
        // R9 out-of-range write leaves all registers unchanged
        do_wr(0, 8'h08); do_wr(1, 8'hFF); rd_chk(1, "R9");
        do_wr(0, 8'h10); do_wr(1, 8'hFF); rd_chk(1, "R9");
        for (int i = 9; i <= 15; i++) begin
            do_wr(0, 8'(i)); rd_chk(1, "R9");
        end
        // R7 start bits
        do_wr(0, 8'h0D); do_wr(1, 8'h18); out_chk();
        // random mix
        for (int n = 0; n < 3000; n++) begin
            int r;
            r = int'($urandom_range(0, 9));
            misc_out = 8'($urandom);
            if (r < 3) do_wr(0, 8'($urandom_range(8'h07, 8'h11)));
            else if (r == 3) do_wr(1, ($urandom_range(0, 1) == 1) ? 8'h05 : 8'($urandom));
            else if (r < 7) do_wr(1, 8'($urandom));
            else if (r == 7) do_wr(0, 8'($urandom));
            else begin
                @(negedge clk);
            end
            rd_chk(1, req_of());
            rd_chk(0, "R1");
            out_chk();
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule